// File: doc/BRIEF.md
# ADC Sample Precision Packer

This block receives raw 12-bit converter samples, one per cycle at most, and packs them into 32-bit words for a downstream FIFO. Before packing, a bit window is cut from each sample according to the selected precision. Each finished word can have its two 16-bit halves exchanged and its byte order reversed before it is offered on the output.

The input has a valid strobe and no ready signal, because a converter cannot be stalled. The output uses valid/ready. A finished word moves into an output register when that register is empty or is being accepted in the same cycle. While `out_valid` is high and `out_ready` is low, the word and the valid flag are held. A completed word that cannot move waits in the accumulator. A sample that arrives while that word is still waiting is discarded, and a one-cycle overflow pulse reports the loss. `flush` closes a partly filled word.

Configuration is assumed to stay constant while a word is being assembled. The window is cut using the configuration present when the sample arrives. Swap and byte order use the configuration present when the word moves to the output register.

Top module: `adc_pack_top`

## Requirements
- R1: After reset, `out_valid` and `overflow` are low.
- R2: With `cfg_prec` = 00 (12-bit), every sample is placed right-aligned in its own 16-bit half-word, with bits 15:12 of that half zero, and two samples make one word.
- R3: With `cfg_prec` = 01 (10-bit), a sample contributes bits [k+9:k], where k is `cfg_offset` limited to at most 2. The result is right-aligned in a 16-bit half, and two samples make one word.
- R4: With `cfg_prec` = 10 or 11 (8-bit), a sample contributes bits [k+7:k], where k is `cfg_offset` limited to at most 4. Four samples fill bytes 0 to 3 of one word.
- R5: The first sample of a word occupies the least significant lane. Later samples fill the higher lanes in arrival order.
- R6: With `cfg_hswap` = 1, bits 31:16 and 15:0 of the packed word are exchanged.
- R7: With `cfg_big_end` = 1, the four bytes of the word are reversed. This reversal is applied after any half-word exchange.
- R8: A `flush` pulse closes a word that holds at least one sample, with zero in the empty lanes. A sample arriving in the same cycle as the flush is included in that word. A flush with no collected sample and no arriving sample emits nothing.
- R9: A word that completes on a clock edge appears on `out_valid`/`out_data` after the next edge if the output register is free at that edge. An offered word stays valid and unchanged until a cycle in which `out_ready` is high.
- R10: If a sample arrives while a completed word is waiting and the output register is held (`out_valid` high, `out_ready` low), the sample is dropped and `overflow` is high for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A sample is present this cycle |
| in_data | input | 12 | Raw converter sample |
| cfg_prec | input | 2 | 00 = 12-bit, 01 = 10-bit, 1x = 8-bit |
| cfg_offset | input | 3 | Lowest kept bit of the window (clamped) |
| cfg_hswap | input | 1 | Exchange the 16-bit halves of each word |
| cfg_big_end | input | 1 | Reverse the byte order of each word |
| flush | input | 1 | Close a partly filled word |
| out_valid | output | 1 | A packed word is offered |
| out_ready | input | 1 | Downstream accepts the offered word |
| out_data | output | 32 | Packed, formatted word |
| overflow | output | 1 | One-cycle pulse: a sample was dropped |

## Verification
Three events can fall on the same clock edge, and each combination is provoked on purpose. The first is a flush with an arriving sample, which must put the sample into the word it closes. The second is a waiting word moving to the output register while a new sample arrives, in which case the sample must start the next word rather than be dropped. The third is a sample arriving while the output is held, which must be dropped and reported. These combinations are driven by directed sequences and then by long random runs of valid, ready and flush. In every cycle the ports are compared against a behavioural model that keeps the collected sample values in a list and formats words from the requirements.

// File: rtl/adc_pack_pkg.sv
package adc_pack_pkg;
  localparam int WORD_W    = 32;
  localparam int BYTES     = WORD_W / 8;
  localparam int HALF_W    = WORD_W / 2;
  localparam int MAX_LANES = BYTES;
  localparam int CNT_W     = $clog2(MAX_LANES + 1);

  typedef enum logic [1:0] {
    PREC_12 = 2'b00,
    PREC_10 = 2'b01,
    PREC_8  = 2'b10,
    PREC_8X = 2'b11
  } prec_e;

  function automatic logic is_byte_mode(input logic [1:0] p);
    return p[1];
  endfunction
endpackage

// File: rtl/adc_pack_window.sv
module adc_pack_window
  import adc_pack_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int OFF_W    = 3
) (
  input  logic [SAMPLE_W-1:0] sample,
  input  logic [1:0]          prec,
  input  logic [OFF_W-1:0]    offset,
  output logic [HALF_W-1:0]   win
);
  localparam logic [OFF_W-1:0]  LIM8   = OFF_W'(SAMPLE_W - 8);
  localparam logic [OFF_W-1:0]  LIM10  = OFF_W'(SAMPLE_W - 10);
  localparam logic [HALF_W-1:0] MASK8  = HALF_W'(8'hFF);
  localparam logic [HALF_W-1:0] MASK10 = HALF_W'(10'h3FF);
  localparam logic [HALF_W-1:0] MASKF  = {{(HALF_W-SAMPLE_W){1'b0}}, {SAMPLE_W{1'b1}}};

  logic [HALF_W-1:0] ext;
  logic [HALF_W-1:0] mask;
  logic [OFF_W-1:0]  lim;
  logic [OFF_W-1:0]  off_eff;

  always_comb begin
    ext = HALF_W'(sample);
    if (is_byte_mode(prec)) begin
      lim  = LIM8;
      mask = MASK8;
    end else if (prec == PREC_10) begin
      lim  = LIM10;
      mask = MASK10;
    end else begin
      lim  = '0;
      mask = MASKF;
    end
    off_eff = (offset > lim) ? lim : offset;
    win     = (ext >> off_eff) & mask;
  end
endmodule

// File: rtl/adc_pack_lanes.sv
module adc_pack_lanes
  import adc_pack_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [HALF_W-1:0] win,
  input  logic              byte_mode,
  input  logic              close,
  input  logic              pop,
  output logic [WORD_W-1:0] acc,
  output logic [CNT_W-1:0]  cnt,
  output logic              full
);
  logic [CNT_W-1:0]  base_cnt;
  logic [WORD_W-1:0] base_acc;
  logic [CNT_W-1:0]  cnt_w;
  logic [CNT_W-1:0]  lanes_now;
  logic              full_d;
  wire  [WORD_W-1:0] acc_d;

  assign base_cnt  = pop ? '0 : cnt;
  assign base_acc  = pop ? '0 : acc;
  assign lanes_now = byte_mode ? CNT_W'(MAX_LANES) : CNT_W'(2);
  assign cnt_w     = wr ? base_cnt + CNT_W'(1) : base_cnt;

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    logic       sel;
    logic [7:0] val;
    assign sel = byte_mode ? (base_cnt == CNT_W'(b)) : (base_cnt == CNT_W'(b / 2));
    if (b % 2 == 0) begin : g_lo
      assign val = win[7:0];
    end else begin : g_hi
      assign val = byte_mode ? win[7:0] : win[15:8];
    end
    assign acc_d[8*b +: 8] = (wr && sel) ? val : base_acc[8*b +: 8];
  end

  always_comb begin
    full_d = pop ? 1'b0 : full;
    if (wr && cnt_w == lanes_now) full_d = 1'b1;
    if (close && cnt_w != '0)     full_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc  <= '0;
      cnt  <= '0;
      full <= 1'b0;
    end else begin
      acc  <= acc_d;
      cnt  <= cnt_w;
      full <= full_d;
    end
  end

  // R5
  lane_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(MAX_LANES));

  // R8
  full_has_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> cnt != '0);
endmodule

// File: rtl/adc_pack_format.sv
module adc_pack_format
  import adc_pack_pkg::*;
(
  input  logic [WORD_W-1:0] word_in,
  input  logic              hswap,
  input  logic              big_end,
  output logic [WORD_W-1:0] word_out
);
  logic [WORD_W-1:0] swapped;
  wire  [WORD_W-1:0] reversed;

  assign swapped = hswap ? {word_in[HALF_W-1:0], word_in[WORD_W-1:HALF_W]} : word_in;

  for (genvar b = 0; b < BYTES; b++) begin : g_rev
    assign reversed[8*b +: 8] = swapped[8*(BYTES-1-b) +: 8];
  end

  assign word_out = big_end ? reversed : swapped;
endmodule

// File: rtl/adc_pack_top.sv
module adc_pack_top
  import adc_pack_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int OFF_W    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_data,
  input  logic [1:0]          cfg_prec,
  input  logic [OFF_W-1:0]    cfg_offset,
  input  logic                cfg_hswap,
  input  logic                cfg_big_end,
  input  logic                flush,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [WORD_W-1:0]   out_data,
  output logic                overflow
);
  logic [HALF_W-1:0] win;
  logic [WORD_W-1:0] pk_acc;
  logic [CNT_W-1:0]  pk_cnt;
  logic              pk_full;
  logic [WORD_W-1:0] fmt_word;
  logic              can_move;
  logic              pop;
  logic              accept;
  logic              drop;

  adc_pack_window #(.SAMPLE_W(SAMPLE_W), .OFF_W(OFF_W)) u_window (
    .sample (in_data),
    .prec   (cfg_prec),
    .offset (cfg_offset),
    .win    (win)
  );

  assign can_move = !out_valid || out_ready;
  assign pop      = pk_full && can_move;
  assign accept   = in_valid && (!pk_full || pop);
  assign drop     = in_valid && pk_full && !pop;

  adc_pack_lanes u_lanes (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (accept),
    .win       (win),
    .byte_mode (is_byte_mode(cfg_prec)),
    .close     (flush),
    .pop       (pop),
    .acc       (pk_acc),
    .cnt       (pk_cnt),
    .full      (pk_full)
  );

  adc_pack_format u_format (
    .word_in  (pk_acc),
    .hswap    (cfg_hswap),
    .big_end  (cfg_big_end),
    .word_out (fmt_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      overflow  <= 1'b0;
    end else begin
      overflow <= drop;
      if (pop) begin
        out_valid <= 1'b1;
        out_data  <= fmt_word;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R10
  overflow_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> $past(in_valid && out_valid && !out_ready));

  // R8
  empty_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !in_valid && !pk_full && pk_cnt == '0) |=> !pk_full);
endmodule

// File: tb/adc_pack_top_tb_top.sv
module adc_pack_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [11:0] in_data = '0;
  logic [1:0]  cfg_prec = 2'b00;
  logic [2:0]  cfg_offset = '0;
  logic        cfg_hswap = 1'b0;
  logic        cfg_big_end = 1'b0;
  logic        flush = 1'b0;
  logic        out_ready = 1'b1;
  logic        out_valid;
  logic [31:0] out_data;
  logic        overflow;

  always #2 clk = ~clk;

  adc_pack_top dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .cfg_prec(cfg_prec), .cfg_offset(cfg_offset), .cfg_hswap(cfg_hswap),
    .cfg_big_end(cfg_big_end), .flush(flush), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .overflow(overflow)
  );

  int    errs = 0;
  int    checks = 0;
  bit    done = 1'b0;
  string tag = "R1";

  int          m_vals[$];
  bit          m_full = 0;
  bit          m_ovalid = 0;
  bit          m_ov = 0;
  logic [31:0] m_odata = '0;

  task automatic chk(bit ok, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int extract(int s);
    int off = cfg_offset;
    if (cfg_prec == 2'b00) return s;
    if (cfg_prec == 2'b01) begin
      if (off > 2) off = 2;
      return (s >> off) & 'h3FF;
    end
    if (off > 4) off = 4;
    return (s >> off) & 'hFF;
  endfunction

  function automatic logic [31:0] build_word();
    logic [31:0] w = '0;
    int lw = cfg_prec[1] ? 8 : 16;
    foreach (m_vals[i]) w |= 32'(m_vals[i]) << (i * lw);
    if (cfg_hswap) w = {w[15:0], w[31:16]};
    if (cfg_big_end) w = {w[7:0], w[15:8], w[23:16], w[31:24]};
    return w;
  endfunction

  task automatic step();
    int          lanes = cfg_prec[1] ? 4 : 2;
    bit          pop = m_full && (!m_ovalid || out_ready);
    bit          n_ovalid = m_ovalid && !out_ready;
    logic [31:0] n_odata = m_odata;
    bit          n_ov = 0;
    if (pop) begin
      n_ovalid = 1;
      n_odata  = build_word();
      m_vals.delete();
      m_full = 0;
    end
    if (in_valid) begin
      if (m_full) n_ov = 1;
      else begin
        m_vals.push_back(extract(in_data));
        if (m_vals.size() == lanes) m_full = 1;
      end
    end
    if (flush && m_vals.size() > 0) m_full = 1;
    @(posedge clk);
    #1;
    m_ovalid = n_ovalid;
    m_odata  = n_odata;
    m_ov     = n_ov;
    chk(out_valid == m_ovalid, "out_valid", 32'(out_valid), 32'(m_ovalid));
    if (m_ovalid) chk(out_data == m_odata, "out_data", out_data, m_odata);
    chk(overflow == m_ov, "overflow", 32'(overflow), 32'(m_ov));
  endtask

  task automatic push(int s, bit fl = 0);
    in_valid = 1; in_data = 12'(s); flush = fl;
    step();
    in_valid = 0; flush = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic drain();
    out_ready = 1; in_valid = 0; flush = 1;
    step();
    flush = 0;
    idle(4);
  endtask

  task automatic random_block(int n, int flush_pct);
    for (int i = 0; i < n; i++) begin
      in_valid  = ($urandom % 100) < 70;
      in_data   = 12'($urandom);
      out_ready = ($urandom % 100) < 50;
      flush     = ($urandom % 100) < flush_pct;
      step();
    end
    in_valid = 0; flush = 0;
    drain();
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    tag = "R1";
    chk(out_valid == 0, "reset out_valid", 32'(out_valid), 0);
    chk(overflow == 0, "reset overflow", 32'(overflow), 0);
    idle(2);

    tag = "R2 R5 R9";
    cfg_prec = 2'b00;
    push('hABC); push('h123); idle(3);
    cfg_offset = 3'd5;
    push('hFFF); push('h800); idle(3);

    tag = "R3";
    cfg_prec = 2'b01;
    for (int o = 0; o < 8; o++) begin
      cfg_offset = 3'(o);
      push('hB5A); push('h6C3); idle(2);
    end

    tag = "R4";
    for (int p = 2; p < 4; p++) begin
      cfg_prec = 2'(p);
      for (int o = 0; o < 8; o++) begin
        cfg_offset = 3'(o);
        push('hF0F); push('h5A5); push('h3C9); push('hE17); idle(2);
      end
    end

    tag = "R6";
    cfg_offset = 0; cfg_prec = 2'b00; cfg_hswap = 1;
    push('h321); push('hDEF); idle(3);
    tag = "R7";
    cfg_hswap = 0; cfg_big_end = 1; cfg_prec = 2'b10;
    push('h011); push('h022); push('h033); push('h044); idle(3);
    cfg_hswap = 1; cfg_prec = 2'b00;
    push('h456); push('h789); idle(3);
    cfg_hswap = 0; cfg_big_end = 0;

    tag = "R8";
    cfg_prec = 2'b10;
    push('h0A5); flush = 1; step(); flush = 0; idle(3);
    push('h011); push('h022); push('h033, 1); idle(3);
    flush = 1; step(); step(); flush = 0; idle(3);
    cfg_prec = 2'b01;
    push('h2AB, 1); idle(3);

    tag = "R9 R10";
    cfg_prec = 2'b10; out_ready = 0;
    for (int i = 0; i < 10; i++) push(16 * i + 3);
    idle(3);
    out_ready = 1; push('h777); out_ready = 0; idle(2);
    out_ready = 1; idle(3);
    out_ready = 0;
    for (int i = 0; i < 8; i++) push('h100 + i);
    out_ready = 1; push('h0EE); idle(3);
    drain();

    tag = "R8 R9 R10 mix";
    for (int k = 0; k < 24; k++) begin
      cfg_prec    = 2'(k % 4);
      cfg_offset  = 3'($urandom);
      cfg_hswap   = k[2];
      cfg_big_end = k[3];
      random_block(1500, (k % 3) * 4);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule